// File: doc/BRIEF.md
# Shared-Bus Pin Register Front End

This block is the register front end of one peripheral pin that several processor cores share. Every core drives its own 34-bit write word toward the pin. The low 32 bits carry data and the top two bits carry a register select. The pin merges all incoming words with a bitwise OR and does no arbitration. The merged word either loads one of three configuration registers (mode, X, Y) or acknowledges a read. The pin sends back a registered 32-bit result and a one-bit flag. Any number of cores may sample these at any time without touching the pin's state.

The pin's signal-generation function is stood in for by a 32-bit accumulator. While the pin is enabled, the accumulator adds X on every cycle. Each time it carries out of bit 31 it sets a "result ready" status bit. Only an acknowledging read clears that bit, and that read travels on the write bus. A cycle in which one core acknowledges while another writes therefore merges into a single corrupted word.

An enable (direction) input holds the pin function at its initial state while it is low, and the configuration registers stay writable during that time. A pin can therefore be fully configured and then released on a chosen cycle. Pins released on the same cycle run in step.

Top module: `pin_regif`

## Requirements
- R1: The pin acts on the bitwise OR of the 34-bit words from all cores. Each core's word occupies bits [34*i+33 : 34*i] of the write bus, with data in the word's bits [31:0] and select in bits [33:32]. Simultaneous writes to the same register leave the OR of their data in it.
- R2: Select 01 loads the mode register, 10 loads X and 11 loads Y. The merged word is captured on one rising edge and applied to the register on the next edge.
- R3: Mode bits [2:1] choose the result source: 00 accumulator, 01 X, 10 Y, 11 the whole mode register. The result output is registered and changes one edge after the state it shows.
- R4: The flag output is registered with the result. Mode bit 0 = 0 gives bit 31 of the result; mode bit 0 = 1 gives the ready bit.
- R5: While enable is high, the accumulator adds X on every rising edge. A carry out of bit 31 on an edge sets the ready bit on that edge.
- R6: A captured word with select 00 and nonzero data is an acknowledge and clears the ready bit on its apply edge, unless a carry sets it on that same edge. Select 00 with zero data has no effect.
- R7: Reading the result and flag needs no activity on the write bus. While the bus is idle the ready bit does not change.
- R8: While enable is low, the accumulator and the ready bit are held at zero. Mode, X and Y remain writable and keep their values.
- R9: A synchronous active-high reset clears all registers, including the result (0) and the flag (0).
- R10: An acknowledge and a register write presented by different cores in the same cycle merge into one word. The register receives the OR of both data fields and the acknowledge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_en_i | input | 1 | Enable; low holds the pin function at its initial state |
| wr_bus_i | input | NUM_CORES*34 | Concatenated write words, one per core |
| rd_result_o | output | 32 | Registered result |
| rd_flag_o | output | 1 | Registered flag |

## Verification
The bench targets the merge. It drives two writes to the same register in one cycle and expects their OR; an arbitrating or last-writer-wins design would show only one core's data. It then drives an acknowledge together with an X write and expects the ready bit to survive and X to hold the merged value. A design that decoded the acknowledge separately from the merge would clear the flag or drop the marker bit from X. A zero-data select-00 word and long idle stretches confirm that only a real acknowledge clears ready; a design that treated every idle word as an acknowledge would lose the flag. The exact cycle on which ready clears is checked, as is an accumulator held at zero while disabled and counting from zero after release; an extra or missing pipeline stage shows as a one-cycle shift.

// File: rtl/pin_regif_pkg.sv
package pin_regif_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_MODE = 2'b01,
    SEL_X    = 2'b10,
    SEL_Y    = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    SRC_ACC  = 2'b00,
    SRC_X    = 2'b01,
    SRC_Y    = 2'b10,
    SRC_MODE = 2'b11
  } src_e;

  localparam int SEL_W        = 2;
  localparam int FLAG_SEL_BIT = 0;
  localparam int SRC_LSB      = 1;
endpackage

// File: rtl/pin_bus_merge.sv
module pin_bus_merge #(
  parameter int NUM_CORES = 4,
  parameter int WORD_W    = 34
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES*WORD_W-1:0] bus_i,
  output logic [WORD_W-1:0]           word_q
);
  logic [WORD_W-1:0] partial [NUM_CORES+1];

  assign partial[0] = '0;
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_or
    assign partial[g+1] = partial[g] | bus_i[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= partial[NUM_CORES];
  end
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pin_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W+SEL_W-1:0] word_i,
  output logic [DATA_W-1:0]       mode_q,
  output logic [DATA_W-1:0]       x_q,
  output logic [DATA_W-1:0]       y_q,
  output logic                    ack_o
);
  sel_e              sel;
  logic [DATA_W-1:0] data;

  assign sel   = sel_e'(word_i[DATA_W +: SEL_W]);
  assign data  = word_i[DATA_W-1:0];
  assign ack_o = (sel == SEL_NONE) && (data != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      case (sel)
        SEL_MODE: mode_q <= data;
        SEL_X:    x_q    <= data;
        SEL_Y:    y_q    <= data;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pin_accum.sv
module pin_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [DATA_W-1:0] step_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] acc_q,
  output logic              ready_q,
  output logic              wrap_o
);
  logic [DATA_W:0] sum;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  assign wrap_o = en_i & sum[DATA_W];

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      acc_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      acc_q <= sum[DATA_W-1:0];
      if (wrap_o)     ready_q <= 1'b1;
      else if (ack_i) ready_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_read_mux.sv
module pin_read_mux
  import pin_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mode_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] result_q,
  output logic              flag_q
);
  src_e              src;
  logic [DATA_W-1:0] pick;

  assign src = src_e'(mode_i[SRC_LSB +: 2]);

  always_comb begin
    case (src)
      SRC_ACC: pick = acc_i;
      SRC_X:   pick = x_i;
      SRC_Y:   pick = y_i;
      default: pick = mode_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      result_q <= pick;
      flag_q   <= mode_i[FLAG_SEL_BIT] ? ready_i : pick[DATA_W-1];
    end
  end
endmodule

// File: rtl/pin_regif.sv
module pin_regif
  import pin_regif_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 pin_en_i,
  input  logic [NUM_CORES*(DATA_W+SEL_W)-1:0] wr_bus_i,
  output logic [DATA_W-1:0]                    rd_result_o,
  output logic                                 rd_flag_o
);
  localparam int WORD_W = DATA_W + SEL_W;

  logic [WORD_W-1:0] merged_q;
  logic [DATA_W-1:0] mode_q, x_q, y_q, acc_q;
  logic              ack, ready_q, wrap;

  pin_bus_merge #(.NUM_CORES(NUM_CORES), .WORD_W(WORD_W)) u_merge (
    .clk(clk), .rst(rst), .bus_i(wr_bus_i), .word_q(merged_q)
  );

  pin_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .word_i(merged_q),
    .mode_q(mode_q), .x_q(x_q), .y_q(y_q), .ack_o(ack)
  );

  pin_accum #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .en_i(pin_en_i), .step_i(x_q), .ack_i(ack),
    .acc_q(acc_q), .ready_q(ready_q), .wrap_o(wrap)
  );

  pin_read_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .mode_i(mode_q), .acc_i(acc_q), .x_i(x_q),
    .y_i(y_q), .ready_i(ready_q), .result_q(rd_result_o), .flag_q(rd_flag_o)
  );
endmodule

// File: rtl/pin_regif_chk.sv
module pin_regif_chk
  import pin_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [DATA_W+SEL_W-1:0] word,
  input logic                    mode_flag,
  input logic [DATA_W-1:0]       x,
  input logic [DATA_W-1:0]       acc,
  input logic                    ready,
  input logic                    wrap,
  input logic [DATA_W-1:0]       rd_result,
  input logic                    rd_flag
);
  sel_e              sel;
  logic [DATA_W-1:0] data;
  logic              is_ack;

  assign sel    = sel_e'(word[DATA_W +: SEL_W]);
  assign data   = word[DATA_W-1:0];
  assign is_ack = (sel == SEL_NONE) && (data != '0);

  assert_x_load_R2: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_X) |=> (x == $past(data)));

  assert_flag_msb_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_flag) |-> (rd_flag == rd_result[DATA_W-1]));

  assert_flag_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $past(mode_flag) |-> (rd_flag == $past(ready)));

  assert_accum_step_R5: assert property (@(posedge clk) disable iff (rst)
    en |=> (acc == $past(acc) + $past(x)));

  assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ready);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (is_ack && en && !wrap) |=> !ready);

  assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && en && !is_ack) |=> ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == '0 && !ready));
endmodule

bind pin_regif pin_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .en(pin_en_i), .word(merged_q),
  .mode_flag(mode_q[0]), .x(x_q), .acc(acc_q), .ready(ready_q),
  .wrap(wrap), .rd_result(rd_result_o), .rd_flag(rd_flag_o)
);

// File: tb/test_pin_regif.sv
module test_pin_regif;
  import pin_regif_pkg::*;

  localparam int NC = 4;
  localparam int DW = 32;
  localparam int WW = DW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin_en = 1'b0;
  logic [NC*WW-1:0] bus = '0;
  logic [DW-1:0] res;
  logic          flag;

  always #4 clk = ~clk;

  pin_regif #(.NUM_CORES(NC), .DATA_W(DW)) i_pin_regif (
    .clk(clk), .rst(rst), .pin_en_i(pin_en), .wr_bus_i(bus),
    .rd_result_o(res), .rd_flag_o(flag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [31:0] r;
    logic        f;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic expect_at(int at, logic [31:0] r, logic f, string tag);
    item_t it;
    it.at = at; it.r = r; it.f = f; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops expected items whose cycle has come
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= cyc) begin
        it = q.pop_front();
        n_cmp++;
        if (res !== it.r || flag !== it.f) begin
          n_bad++;
          $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
                   it.tag, res, flag, it.r, it.f);
        end
      end
    end
  end

  task automatic put(int core, sel_e s, logic [31:0] d);
    bus[core*WW +: WW] = {s, d};
  endtask

  task automatic commit();
    @(negedge clk);
    bus = '0;
  endtask

  task automatic write1(int core, sel_e s, logic [31:0] d);
    put(core, s, d);
    commit();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_check(logic [31:0] r, logic f, string tag);
    idle(3);
    expect_at(cyc + 1, r, f, tag);
    idle(2);
  endtask

  // one cycle of X = step, then X = 0: adds step once
  task automatic pulse_add(logic [31:0] step);
    write1(0, SEL_X, step);
    write1(0, SEL_X, 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: result=%h flag=%b expected run to finish", res, flag);
      summary();
      $finish;
    end
  end

  initial begin
    int n0, c;
    idle(5);
    rst = 1'b0;
    expect_at(cyc + 1, 32'h0, 1'b0, "R9 reset state");
    idle(2);

    // register loads while disabled (R2, R3, R4, R8)
    write1(2, SEL_X, 32'h8000_1234);
    write1(0, SEL_MODE, 32'h2);            // source X, flag = bit 31
    c = cyc;
    expect_at(c + 2, 32'h8000_1234, 1'b1, "R2/R4 X load at second edge");
    idle(4);
    write1(3, SEL_Y, 32'h0BAD_F00D);
    write1(1, SEL_MODE, 32'h4);            // source Y
    settle_check(32'h0BAD_F00D, 1'b0, "R3 Y source");
    write1(0, SEL_MODE, 32'h6);            // source mode
    settle_check(32'h6, 1'b0, "R3 mode source");

    // merged writes (R1)
    write1(0, SEL_MODE, 32'h2);
    put(0, SEL_X, 32'h00F0_0F00);
    put(1, SEL_X, 32'h0F00_00F0);
    commit();
    settle_check(32'h0FF0_0FF0, 1'b0, "R1 OR of simultaneous writes");
    put(0, SEL_NONE, 32'h0);
    put(2, SEL_NONE, 32'h0);
    commit();
    settle_check(32'h0FF0_0FF0, 1'b0, "R6 zero-data select 00 no effect");

    // hold while disabled (R8)
    write1(0, SEL_X, 32'h5);
    write1(0, SEL_MODE, 32'h0);            // source acc, flag = bit 31
    idle(5);
    settle_check(32'h0, 1'b0, "R8 accumulator held while disabled");

    // run (R5)
    pin_en = 1'b1;
    n0 = cyc;
    for (int k = 0; k < 8; k++)
      expect_at(n0 + 1 + k, 32'(5 * k), 1'b0, "R5 accumulate X per edge");
    idle(10);
    pin_en = 1'b0;
    c = cyc;
    expect_at(c + 2, 32'h0, 1'b0, "R8 cleared when enable falls");
    idle(4);

    // wrap sets ready (R5)
    write1(0, SEL_X, 32'h0);
    write1(0, SEL_MODE, 32'h1);            // source acc, flag = ready
    pin_en = 1'b1;
    settle_check(32'h0, 1'b0, "R5 idle with X=0");
    pulse_add(32'h8000_0000);
    settle_check(32'h8000_0000, 1'b0, "R5 no carry yet");
    pulse_add(32'h8000_0000);
    settle_check(32'h0, 1'b1, "R5 carry sets ready");

    // quiet reads (R7)
    for (int k = 0; k < 4; k++) begin
      idle(4);
      expect_at(cyc + 1, 32'h0, 1'b1, "R7 ready kept while bus idle");
    end
    idle(2);
    write1(2, SEL_NONE, 32'h0);
    settle_check(32'h0, 1'b1, "R6 zero-data word is not an acknowledge");

    // acknowledge timing (R6)
    write1(1, SEL_NONE, 32'h1);
    c = cyc;
    expect_at(c + 1, 32'h0, 1'b1, "R6 flag before apply edge");
    expect_at(c + 2, 32'h0, 1'b0, "R6 acknowledge clears ready");
    idle(4);

    // re-arm, then ack collides with a write (R10)
    pulse_add(32'h8000_0000);
    pulse_add(32'h8000_0000);
    settle_check(32'h0, 1'b1, "R5 ready set again");
    put(0, SEL_NONE, 32'h0000_0100);
    put(1, SEL_X, 32'h0000_0003);
    commit();
    write1(3, SEL_MODE, 32'h3);            // source X, flag = ready
    settle_check(32'h0000_0103, 1'b1, "R10 ack merged into write, ready kept");

    // reset mid-run (R9)
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    expect_at(cyc + 1, 32'h0, 1'b0, "R9 reset clears outputs");
    idle(3);

    while (q.size() > 0) idle(1);
    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule